// File: doc/BRIEF.md
# I2C Serial Clock Rate Generator

This block produces the serial clock waveform of an I2C master from a fast functional clock. A programmable prescaler divides the functional clock into an internal sampling tick. Each clock period then consists of a low phase and a high phase, each lasting a programmed number of ticks plus a fixed hardware offset. The low phase adds seven ticks and the high phase adds five. The resulting bit rate is fclk / ((psc+1) * (low + 7 + high + 5)). As an example, a 48 MHz clock with psc = 1, low = 111 and high = 117 gives exactly 100 kHz.

Each timing input is a 16-bit word that holds two counts. The standard/fast count sits in the lower byte and the high-speed count sits in the upper byte. A mode select input chooses which byte applies. The generator takes its settings while it is disabled and keeps them frozen while it runs. This lets software load a new rate and then enable the generator. The generator also outputs strobes for a neighbouring bit engine:
- the sampling tick;
- a marker at the start of each low phase and of each high phase;
- a marker in the middle of each low phase, where data may change;
- a marker in the middle of each high phase, where data is sampled.

Top module: `sclgen_top`

## Requirements
- R1: While `en` is low, at every clock edge `scl_o` is set high and the generator stops. In the cycle after any edge that samples `en` low, `scl_o` = 1 and `tick_o`, `fall_o`, `rise_o`, `mid_lo_o` and `mid_hi_o` are all 0.
- R2: While running, `tick_o` pulses for one cycle every psc+1 clock cycles. The first pulse comes psc+1 cycles after the enabling edge, counting the first running cycle as cycle 1.
- R3: At the edge that first samples `en` high, `scl_o` goes low. It stays low for exactly (low + 7) * (psc + 1) clock cycles.
- R4: The high phase lasts exactly (high + 5) * (psc + 1) clock cycles. The next low phase then starts, so the waveform repeats.
- R5: With `hs_sel_i` = 0, the low and high counts come from bits [7:0] of `lo_cfg_i` and `hi_cfg_i`. With `hs_sel_i` = 1, they come from bits [15:8].
- R6: `psc_i`, `lo_cfg_i`, `hi_cfg_i` and `hs_sel_i` are captured at each edge where `en` is low. Changes to these inputs while the generator runs have no effect on the waveform.
- R7: `fall_o` is 1 for exactly the first cycle of every low phase, including the first low phase after enable. `rise_o` is 1 for exactly the first cycle of every high phase.
- R8: `mid_lo_o` pulses on the low-phase tick with index floor((low+7)/2). `mid_hi_o` pulses on the high-phase tick with index floor((high+5)/2). Tick indices count from 0 within each phase, and each strobe fires once per phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low holds SCL high and loads settings |
| psc_i | input | 8 | Prescale value; tick period is psc+1 cycles |
| lo_cfg_i | input | 16 | Low counts: [7:0] standard/fast, [15:8] high-speed |
| hi_cfg_i | input | 16 | High counts: [7:0] standard/fast, [15:8] high-speed |
| hs_sel_i | input | 1 | 1 selects the high-speed (upper byte) counts |
| scl_o | output | 1 | Serial clock level |
| tick_o | output | 1 | Internal sampling tick strobe |
| fall_o | output | 1 | First cycle of a low phase |
| rise_o | output | 1 | First cycle of a high phase |
| mid_lo_o | output | 1 | Middle of low phase (data change point) |
| mid_hi_o | output | 1 | Middle of high phase (data sample point) |

## Verification
Several properties are checked on every cycle:
- the idle level after a disable;
- the exact spacing of ticks against the captured prescale;
- that SCL holds its level between ticks;
- that the phase-start markers agree with the SCL edges;
- that the four phase strobes never overlap and mid-phase strobes land on ticks;
- that settings stay frozen while running.

The absolute phase lengths, the mid-phase positions, the byte chosen by the mode select, and the fact that inputs changed mid-run are ignored can only be shown by the bench's scenarios. Each scenario measures one full SCL period at the ports against lengths computed from the programmed values.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
  localparam int unsigned LO_EXTRA = 7;
  localparam int unsigned HI_EXTRA = 5;

  function automatic int unsigned low_span(input int unsigned cnt);
    return cnt + LO_EXTRA;
  endfunction

  function automatic int unsigned high_span(input int unsigned cnt);
    return cnt + HI_EXTRA;
  endfunction

  function automatic int unsigned mid_index(input int unsigned span);
    return span >> 1;
  endfunction
endpackage

// File: rtl/sclgen_prescaler.sv
module sclgen_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] div_cnt;

  assign tick = run && (div_cnt == psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_cnt <= '0;
    else if (!run)   div_cnt <= '0;
    else if (tick)   div_cnt <= '0;
    else             div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase #(
  parameter int PH_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            start,
  input  logic            run,
  input  logic            tick,
  input  logic [PH_W-1:0] lo_len,
  input  logic [PH_W-1:0] hi_len,
  output logic            scl,
  output logic            fall_mark,
  output logic            rise_mark,
  output logic            mid_lo,
  output logic            mid_hi
);
  logic [PH_W-1:0] ph_cnt;
  logic [PH_W-1:0] cur_len;
  logic            last_tick;
  logic            mid_tick;

  assign cur_len   = scl ? hi_len : lo_len;
  assign last_tick = tick && (ph_cnt == cur_len - PH_W'(1));
  assign mid_tick  = run && tick && (ph_cnt == (cur_len >> 1));
  assign mid_lo    = mid_tick && !scl;
  assign mid_hi    = mid_tick && scl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl       <= 1'b1;
      ph_cnt    <= '0;
      fall_mark <= 1'b0;
      rise_mark <= 1'b0;
    end else if (!en) begin
      scl       <= 1'b1;
      ph_cnt    <= '0;
      fall_mark <= 1'b0;
      rise_mark <= 1'b0;
    end else if (start) begin
      scl       <= 1'b0;
      ph_cnt    <= '0;
      fall_mark <= 1'b1;
      rise_mark <= 1'b0;
    end else begin
      fall_mark <= last_tick && scl;
      rise_mark <= last_tick && !scl;
      if (last_tick) begin
        scl    <= ~scl;
        ph_cnt <= '0;
      end else if (tick) begin
        ph_cnt <= ph_cnt + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/sclgen_top.sv
module sclgen_top #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [PSC_W-1:0]   psc_i,
  input  logic [2*CNT_W-1:0] lo_cfg_i,
  input  logic [2*CNT_W-1:0] hi_cfg_i,
  input  logic               hs_sel_i,
  output logic               scl_o,
  output logic               tick_o,
  output logic               fall_o,
  output logic               rise_o,
  output logic               mid_lo_o,
  output logic               mid_hi_o
);
  import sclgen_pkg::*;

  localparam int PH_W = CNT_W + 4;

  logic             run;
  logic             start;
  logic [PSC_W-1:0] psc_q;
  logic [PH_W-1:0]  lo_len_q;
  logic [PH_W-1:0]  hi_len_q;
  logic [CNT_W-1:0] lo_sel;
  logic [CNT_W-1:0] hi_sel;

  assign lo_sel = hs_sel_i ? lo_cfg_i[2*CNT_W-1:CNT_W] : lo_cfg_i[CNT_W-1:0];
  assign hi_sel = hs_sel_i ? hi_cfg_i[2*CNT_W-1:CNT_W] : hi_cfg_i[CNT_W-1:0];
  assign start  = en && !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      psc_q    <= '0;
      lo_len_q <= PH_W'(LO_EXTRA);
      hi_len_q <= PH_W'(HI_EXTRA);
    end else if (!en) begin
      run      <= 1'b0;
      psc_q    <= psc_i;
      lo_len_q <= PH_W'(low_span(32'(lo_sel)));
      hi_len_q <= PH_W'(high_span(32'(hi_sel)));
    end else begin
      run      <= 1'b1;
    end
  end

  sclgen_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .psc  (psc_q),
    .tick (tick_o)
  );

  sclgen_phase #(.PH_W(PH_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .start    (start),
    .run      (run),
    .tick     (tick_o),
    .lo_len   (lo_len_q),
    .hi_len   (hi_len_q),
    .scl      (scl_o),
    .fall_mark(fall_o),
    .rise_mark(rise_o),
    .mid_lo   (mid_lo_o),
    .mid_hi   (mid_hi_o)
  );
endmodule

// File: rtl/sclgen_chk.sv
module sclgen_chk #(
  parameter int PSC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             run,
  input logic [PSC_W-1:0] psc_q,
  input logic             scl_o,
  input logic             tick_o,
  input logic             fall_o,
  input logic             rise_o,
  input logic             mid_lo_o,
  input logic             mid_hi_o
);
  logic [PSC_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap <= '0;
    else if (!run || tick_o)   gap <= '0;
    else                       gap <= gap + 1'b1;
  end

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_o && !tick_o && !fall_o && !rise_o && !mid_lo_o && !mid_hi_o));

  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (gap == psc_q));

  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run && !tick_o) |=> $stable(scl_o));

  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run) |=> $stable(psc_q));

  a_r7_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> (!scl_o && $past(scl_o)));

  a_r7_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> (scl_o && !$past(scl_o)));

  a_r8_mid_lo_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    mid_lo_o |-> (tick_o && !scl_o));

  a_r8_mid_hi_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    mid_hi_o |-> (tick_o && scl_o));

  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_o, rise_o, mid_lo_o, mid_hi_o}));
endmodule

bind sclgen_top sclgen_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .run     (run),
  .psc_q   (psc_q),
  .scl_o   (scl_o),
  .tick_o  (tick_o),
  .fall_o  (fall_o),
  .rise_o  (rise_o),
  .mid_lo_o(mid_lo_o),
  .mid_hi_o(mid_hi_o)
);

// File: tb/sclgen_top_tb.sv
module sclgen_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [7:0]  psc_i = '0;
  logic [15:0] lo_cfg_i = '0;
  logic [15:0] hi_cfg_i = '0;
  logic        hs_sel_i = 1'b0;
  logic        scl_o, tick_o, fall_o, rise_o, mid_lo_o, mid_hi_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sclgen_top u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .psc_i(psc_i), .lo_cfg_i(lo_cfg_i),
    .hi_cfg_i(hi_cfg_i), .hs_sel_i(hs_sel_i), .scl_o(scl_o), .tick_o(tick_o),
    .fall_o(fall_o), .rise_o(rise_o), .mid_lo_o(mid_lo_o), .mid_hi_o(mid_hi_o)
  );

  function automatic int exp_low(input int psc, input int lo);
    return (lo + 7) * (psc + 1);
  endfunction

  function automatic int exp_high(input int psc, input int hi);
    return (hi + 5) * (psc + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // One scenario: program while idle, enable, measure a full period, disable.
  task automatic run_case(input int psc, input int lo16, input int hi16, input bit hs);
    int lo, hi, tl, th, p;
    int rise_k, fall2_k, mlo_k, mhi_k, nmlo, nmhi, first_tick, last_tick;
    bit tick_ok, rise_mark_ok;
    lo = hs ? ((lo16 >> 8) & 255) : (lo16 & 255);
    hi = hs ? ((hi16 >> 8) & 255) : (hi16 & 255);
    p  = psc + 1;
    tl = exp_low(psc, lo);
    th = exp_high(psc, hi);
    rise_k = -1; fall2_k = -1; mlo_k = -1; mhi_k = -1; nmlo = 0; nmhi = 0;
    first_tick = -1; last_tick = -1; tick_ok = 1'b1; rise_mark_ok = 1'b0;

    @(negedge clk);
    psc_i = 8'(psc); lo_cfg_i = 16'(lo16); hi_cfg_i = 16'(hi16); hs_sel_i = hs;
    @(negedge clk);
    en = 1'b1;
    for (int k = 1; k <= tl + th + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        chk(scl_o == 1'b0, "R3 scl low right after enable", int'(scl_o), 0);
        chk(fall_o == 1'b1, "R7 fall marker on first low cycle", int'(fall_o), 1);
      end
      if (k == 2) begin
        // R6: scramble settings while running
        psc_i = 8'($urandom_range(0, 255));
        lo_cfg_i = 16'($urandom); hi_cfg_i = 16'($urandom); hs_sel_i = ~hs;
      end
      if (k > 1 && rise_k < 0 && scl_o) begin
        rise_k = k; rise_mark_ok = rise_o;
      end
      if (k > 1 && fall_o && fall2_k < 0) fall2_k = k;
      if (mid_lo_o && k <= tl) begin nmlo++; mlo_k = k; end
      if (mid_hi_o) begin nmhi++; mhi_k = k; end
      if (tick_o) begin
        if (first_tick < 0) first_tick = k;
        else if (k - last_tick != p) tick_ok = 1'b0;
        last_tick = k;
      end
    end
    chk(first_tick == 1 + psc, "R2 first tick position", first_tick, 1 + psc);
    chk(tick_ok, "R2 tick spacing", int'(tick_ok), 1);
    chk(rise_k == 1 + tl, hs ? "R5 R3 low length (hs counts)" : "R3 R6 low length",
        rise_k - 1, tl);
    chk(rise_mark_ok, "R7 rise marker on first high cycle", int'(rise_mark_ok), 1);
    chk(fall2_k == 1 + tl + th, hs ? "R5 R4 high length (hs counts)" : "R4 R6 high length",
        fall2_k - rise_k, th);
    chk(nmlo == 1 && mlo_k == 1 + psc + ((lo + 7) / 2) * p, "R8 mid low position",
        mlo_k, 1 + psc + ((lo + 7) / 2) * p);
    chk(nmhi == 1 && mhi_k == 1 + tl + psc + ((hi + 5) / 2) * p, "R8 mid high position",
        mhi_k, 1 + tl + psc + ((hi + 5) / 2) * p);
    en = 1'b0;
    @(negedge clk);
    chk(scl_o && !tick_o && !fall_o && !rise_o && !mid_lo_o && !mid_hi_o,
        "R1 idle after disable", int'(scl_o), 1);
  endtask

  initial begin
    int seed;
    seed = $urandom(20240611);
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b1 && !tick_o && !fall_o && !rise_o, "R1 reset state", int'(scl_o), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(scl_o == 1'b1 && !tick_o, "R1 idle while disabled", int'(scl_o), 1);

    run_case(1, 5, 7, 1'b0);                 // 1 MHz from 48 MHz
    run_case(0, 0, 0, 1'b0);                 // shortest phases
    run_case(1, 111, 117, 1'b0);             // 100 kHz from 48 MHz
    run_case(23, 13, 15, 1'b0);              // 100 kHz from 96 MHz
    run_case(0, 16'h0A_63, 16'h0C_44, 1'b1); // high-speed byte selected (R5)
    run_case(2, 16'h03_00, 16'h01_FF, 1'b1);
    run_case(0, 255, 255, 1'b0);             // largest counts
    for (int i = 0; i < 6; i++) begin
      run_case(int'($urandom_range(0, 3)), int'($urandom_range(0, 65535)),
               int'($urandom_range(0, 65535)), 1'($urandom_range(0, 1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule